// File: doc/BRIEF.md
# Fall-Through Transmit Word Queue

This block sits between a CPU-side register pair and a serial transmitter controller. Software first sets a small command field and then writes a data byte. The data write merges the byte with the command field currently held and pushes the resulting word into a short queue. Words in the queue move on their own toward the output slot, one slot per clock. The transmitter takes the oldest word with a pop strobe once that word has reached the output slot.

The CPU side sees two flags. One reports that no word is held anywhere in the queue. The other reports that every slot is occupied. Writing while the queue is full does not stall or reject the write: the newest word, in the input slot, is replaced and its old contents are lost. The only exception is a pop in that same cycle, which frees a slot so that the write is kept as a new word.

Top module: `txw_fifo`

## Requirements
- R1: A data write pushes the word {command register, data byte}, with the command in bits 11:8 and the data in bits 7:0. A command write in the same cycle as a data write does not affect that push; it applies to later pushes.
- R2: While reset is high, and after it is released, all slots are empty, the empty flag is 1, the full flag is 0, out_valid is 0, tx_word is 0 and the command register is 0.
- R3: A word moves one slot toward the output per clock whenever the next slot is free or is being vacated in the same edge. With DEPTH=3, a word written into an empty queue raises out_valid two edges after the edge that captured it.
- R4: The empty flag is low directly after the edge that captures a write.
- R5: The full flag is high exactly when DEPTH words are held. Three writes in a row with no pop make it high after the third write's edge. Empty and full are never high together.
- R6: A write while full, with no pop in the same cycle, replaces the newest word. Older words are untouched and the full flag stays high.
- R7: A pop while out_valid is high loads the output-slot word into tx_word at that edge. Words leave in write order.
- R8: A pop while out_valid is low is ignored. This covers an empty queue and a word still falling through. tx_word holds its value and the queue contents are unchanged.
- R9: Popping the last held word raises the empty flag. Popping from a full queue with no write in that cycle drops the full flag.
- R10: A write and a pop in the same cycle on a full queue both take effect. No word is lost and the full flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous transceiver reset, active high |
| cmd_wr | input | 1 | Load strobe for the command register |
| cmd_in | input | CMD_W | Command field value |
| data_wr | input | 1 | Data byte write; pushes a word |
| data_in | input | DATA_W | Data byte value |
| pop | input | 1 | Transmitter takes the output-slot word |
| empty | output | 1 | No word held in any slot |
| full | output | 1 | All slots occupied |
| out_valid | output | 1 | Output slot holds a word |
| tx_word | output | CMD_W+DATA_W | Last word taken by the transmitter |

## Verification
Two collisions are targeted. The first is a write and a pop landing together on a full queue. The bench fills the queue with three back-to-back writes and then drives both strobes in one cycle. It expects full to stay high and every word, the new one included, to drain later in write order. The second is a command write coinciding with a data write: the pushed word must carry the old command, while the next push carries the new one. Long random stretches then let pops, overwrites and fall-through moves meet in every combination. A behavioural queue with slot positions judges every clock.

// File: rtl/txw_fifo_pkg.sv
package txw_fifo_pkg;

   localparam int unsigned DEF_DATA_W = 8;
   localparam int unsigned DEF_CMD_W  = 4;
   localparam int unsigned DEF_DEPTH  = 3;

   typedef enum logic [1:0] {
      SLOT_HOLD  = 2'b00,
      SLOT_DRAIN = 2'b01,
      SLOT_FILL  = 2'b10,
      SLOT_SWAP  = 2'b11
   } slot_act_e;

endpackage

// File: rtl/txw_fifo_merge.sv
module txw_fifo_merge
   import txw_fifo_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned CMD_W  = DEF_CMD_W,
   localparam int unsigned WORD_W = DATA_W + CMD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_in,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   output logic              push,
   output logic [WORD_W-1:0] push_word
);

   logic [CMD_W-1:0] cmd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q <= '0;
      end else if (cmd_wr) begin
         cmd_q <= cmd_in;
      end
   end

   always_comb begin
      push      = data_wr;
      push_word = {cmd_q, data_in};
   end

   // R1: the command used by a push only changes through a command write
   assert_cmd_held_R1: assert property (@(posedge clk) disable iff (rst)
      !cmd_wr |=> $stable(cmd_q));

endmodule

// File: rtl/txw_fifo_slot.sv
module txw_fifo_slot
   import txw_fifo_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_DATA_W + DEF_CMD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              leave,
   output logic              valid,
   output logic [WORD_W-1:0] word
);

   slot_act_e act;

   always_comb begin
      act = slot_act_e'({load, leave});
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         word  <= '0;
      end else begin
         unique case (act)
            SLOT_FILL, SLOT_SWAP: begin
               valid <= 1'b1;
               word  <= load_word;
            end
            SLOT_DRAIN: valid <= 1'b0;
            default:    valid <= valid;
         endcase
      end
   end

   // R3: a slot never hands on a word it does not hold
   assert_no_phantom_move_R3: assert property (@(posedge clk) disable iff (rst)
      leave |-> valid);

endmodule

// File: rtl/txw_fifo.sv
module txw_fifo
   import txw_fifo_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned CMD_W  = DEF_CMD_W,
   parameter int unsigned DEPTH  = DEF_DEPTH,
   localparam int unsigned WORD_W = DATA_W + CMD_W,
   localparam int unsigned LAST   = DEPTH - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_in,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              pop,
   output logic              empty,
   output logic              full,
   output logic              out_valid,
   output logic [WORD_W-1:0] tx_word
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("txw_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1 || CMD_W < 1) begin : g_bad_width
      $error("txw_fifo: DATA_W and CMD_W must be non-zero");
   end

   logic              push;
   logic [WORD_W-1:0] push_word;
   logic [DEPTH-1:0]  valid;
   logic [DEPTH-1:0]  leave;
   logic [DEPTH-1:0]  load;
   logic [WORD_W-1:0] word  [DEPTH];
   logic [WORD_W-1:0] lword [DEPTH];
   logic              pop_ok;

   txw_fifo_merge #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_merge (
      .clk       (clk),
      .rst       (rst),
      .cmd_wr    (cmd_wr),
      .cmd_in    (cmd_in),
      .data_wr   (data_wr),
      .data_in   (data_in),
      .push      (push),
      .push_word (push_word)
   );

   assign pop_ok = pop & valid[LAST];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == LAST) begin : g_out
         assign leave[i] = pop_ok;
      end else begin : g_mid
         // a slot moves on when any slot ahead is free or the output drains
         assign leave[i] = valid[i] & (~(&valid[LAST:i+1]) | pop_ok);
      end

      if (i == 0) begin : g_in
         assign load[i]  = push;
         assign lword[i] = push_word;
      end else begin : g_fwd
         assign load[i]  = leave[i-1];
         assign lword[i] = word[i-1];
      end

      txw_fifo_slot #(.WORD_W(WORD_W)) u_slot (
         .clk       (clk),
         .rst       (rst),
         .load      (load[i]),
         .load_word (lword[i]),
         .leave     (leave[i]),
         .valid     (valid[i]),
         .word      (word[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_word <= '0;
      end else if (pop_ok) begin
         tx_word <= word[LAST];
      end
   end

   always_comb begin
      empty     = ~(|valid);
      full      = &valid;
      out_valid = valid[LAST];
   end

   assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
      !(empty && full));

   assert_write_clears_empty_R4: assert property (@(posedge clk) disable iff (rst)
      data_wr |=> !empty);

   assert_idle_pop_holds_R8: assert property (@(posedge clk) disable iff (rst)
      (pop && !out_valid) |=> $stable(tx_word));

   assert_pop_delivers_R7: assert property (@(posedge clk) disable iff (rst)
      (pop && out_valid) |=> tx_word == $past(word[LAST]));

   assert_overwrite_keeps_full_R6: assert property (@(posedge clk) disable iff (rst)
      (full && data_wr && !pop) |=> full);

   assert_pop_from_full_drops_R9: assert property (@(posedge clk) disable iff (rst)
      (full && pop && !data_wr) |=> !full);

   assert_write_pop_on_full_R10: assert property (@(posedge clk) disable iff (rst)
      (full && pop && data_wr) |=> full);

endmodule

// File: tb/txw_fifo_test.sv
`timescale 1ns/1ps
module txw_fifo_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        cmd_wr, data_wr, pop;
   logic [3:0]  cmd_in;
   logic [7:0]  data_in;
   logic        empty, full, out_valid;
   logic [11:0] tx_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [11:0] mq_word[$];
   int          mq_pos[$];
   logic [3:0]  cmd_m;
   logic [11:0] tx_m;

   always #2.5 clk = ~clk;

   txw_fifo uut (
      .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
      .data_wr(data_wr), .data_in(data_in), .pop(pop),
      .empty(empty), .full(full), .out_valid(out_valid), .tx_word(tx_word)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit ov;
      ov = (mq_pos.size() > 0) && (mq_pos[0] == 2);
      chk(empty === (mq_pos.size() == 0), "R4/R9 empty", empty, mq_pos.size() == 0);
      chk(full === (mq_pos.size() == 3), "R5 full", full, mq_pos.size() == 3);
      chk(out_valid === ov, "R3 out_valid", out_valid, ov);
      chk(tx_word === tx_m, "R7 tx_word", tx_word, tx_m);
   endtask

   task automatic model(input bit w, input logic [7:0] d, input bit cw,
                        input logic [3:0] c, input bit p);
      logic [11:0] nw;
      bit full_m, pop_ok;
      int lim;
      nw     = {cmd_m, d};
      full_m = (mq_pos.size() == 3);
      pop_ok = p && mq_pos.size() > 0 && mq_pos[0] == 2;
      lim    = 3;
      if (pop_ok) begin
         tx_m = mq_word[0];
         void'(mq_word.pop_front());
         void'(mq_pos.pop_front());
      end
      for (int k = 0; k < mq_pos.size(); k++) begin
         if (mq_pos[k] + 1 < lim) mq_pos[k] = mq_pos[k] + 1;
         lim = mq_pos[k];
      end
      if (w) begin
         if (full_m && !pop_ok) begin
            mq_word[mq_word.size()-1] = nw;
         end else begin
            mq_word.push_back(nw);
            mq_pos.push_back(0);
         end
      end
      if (cw) cmd_m = c;
   endtask

   task automatic step(input bit w, input logic [7:0] d, input bit cw,
                       input logic [3:0] c, input bit p);
      @(negedge clk);
      data_wr = w; data_in = d; cmd_wr = cw; cmd_in = c; pop = p;
      @(posedge clk);
      #1;
      model(w, d, cw, c, p);
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, 4'h0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; data_wr = 0; cmd_wr = 0; pop = 0; data_in = 0; cmd_in = 0;
      repeat (3) @(posedge clk);
      #1;
      mq_word.delete(); mq_pos.delete(); cmd_m = '0; tx_m = '0;
      chk(empty === 1'b1 && full === 1'b0 && out_valid === 1'b0 && tx_word === 12'h0,
          "R2 reset state", {empty, full, out_valid}, 3'b100);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #500000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: command before data, then word reaches output after two edges (R3)
      step(0, 8'h00, 1, 4'hA, 0);
      step(1, 8'h5C, 0, 4'h0, 0);
      chk(empty === 1'b0, "R4 empty low after write", empty, 0);
      step(0, 8'h00, 0, 4'h0, 1);          // R8: word still falling through
      chk(out_valid === 1'b0 && tx_word === 12'h000, "R8 pop during fall-through", tx_word, 0);
      step(0, 8'h00, 0, 4'h0, 0);
      chk(out_valid === 1'b1, "R3 out_valid after two moves", out_valid, 1);
      step(0, 8'h00, 0, 4'h0, 1);
      chk(tx_word === 12'hA5C, "R1 merged word", tx_word, 12'hA5C);
      chk(empty === 1'b1, "R9 empty after last pop", empty, 1);
      step(0, 8'h00, 0, 4'h0, 1);          // R8: pop while empty
      chk(tx_word === 12'hA5C, "R8 pop while empty holds", tx_word, 12'hA5C);
      // R1: same-cycle command and data write uses the old command
      step(1, 8'h11, 1, 4'h3, 0);
      step(1, 8'h22, 0, 4'h0, 0);
      idle(2);
      step(0, 8'h00, 0, 4'h0, 1);
      chk(tx_word === 12'hA11, "R1 same-cycle command ignored", tx_word, 12'hA11);
      idle(1);
      step(0, 8'h00, 0, 4'h0, 1);
      chk(tx_word === 12'h322, "R1 new command applies later", tx_word, 12'h322);
      // R5 / R6: fill, then overwrite the newest
      step(1, 8'h01, 0, 4'h0, 0);
      step(1, 8'h02, 0, 4'h0, 0);
      step(1, 8'h03, 0, 4'h0, 0);
      chk(full === 1'b1, "R5 full after three writes", full, 1);
      step(1, 8'h04, 0, 4'h0, 0);
      chk(full === 1'b1, "R6 full kept on overwrite", full, 1);
      // R10: write and pop together on a full queue
      step(1, 8'h05, 0, 4'h0, 1);
      chk(full === 1'b1 && tx_word === 12'h301, "R10 write+pop on full", tx_word, 12'h301);
      step(0, 8'h00, 0, 4'h0, 1);
      chk(tx_word === 12'h302 && full === 1'b0, "R9 full drops on pop", tx_word, 12'h302);
      step(0, 8'h00, 0, 4'h0, 1);
      chk(tx_word === 12'h304, "R6 overwritten word replaced", tx_word, 12'h304);
      idle(1);
      step(0, 8'h00, 0, 4'h0, 1);
      chk(tx_word === 12'h305, "R10 no word lost", tx_word, 12'h305);
      // random mix
      for (int n = 0; n < 2000; n++) begin
         step($urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 3) == 0,
              4'($urandom), $urandom_range(0, 1) == 1);
         if (n == 1000) do_reset();
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule